// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Manager

This block keeps an asynchronous page-mode DRAM alive. Out of reset it holds both strobes inactive for a long settling pause, then runs a short train of CAS-before-RAS (CBR) cycles that prime the device. After that it schedules one CBR refresh per fixed interval, which spreads the row refreshes evenly over the retention period. When a host asks the memory to sleep, the block issues a burst of refresh cycles, places the DRAM in self-refresh, and keeps it there. When the host withdraws the request, the block brings the DRAM out of self-refresh, waits out the recovery time and issues a second burst.

The manager shares the strobes with an access controller. It raises `ref_req` whenever it needs the bus and starts a strobe cycle only in a cycle where `grant` is high. The access controller is expected to keep `grant` high until `ref_req` drops. A refresh that falls due while the grant is withheld is not lost. It is counted as pending, up to a fixed ceiling, and pending refreshes are issued back to back once the grant returns. Every timing window is a parameter expressed in clock cycles. The strobes come straight from flip-flops.

Controller states: `ST_PWR_WAIT` (settling pause), `ST_INIT_CBR` (priming train), `ST_IDLE`, `ST_REQ` (refresh due, waiting for grant), `ST_CBR` (refresh cycle running), `ST_SR_BURST_IN` (burst before sleep), `ST_SELF` (self-refresh held), `ST_SR_EXIT` (strobes high for recovery) and `ST_SR_BURST_OUT` (burst after sleep). The transitions are as follows:
- Pause done: `ST_PWR_WAIT` to `ST_INIT_CBR`.
- Train done: `ST_INIT_CBR` to `ST_IDLE`.
- Sleep request: `ST_IDLE` to `ST_SR_BURST_IN`, or to `ST_SELF` when the burst length is zero.
- Refresh due: `ST_IDLE` to `ST_REQ`.
- Grant seen: `ST_REQ` to `ST_CBR`.
- Cycle done: `ST_CBR` back to `ST_REQ` if more refreshes are pending, otherwise to `ST_IDLE`.
- Burst done: `ST_SR_BURST_IN` to `ST_SELF`.
- Release: `ST_SELF` to `ST_SR_EXIT`.
- Recovery done: `ST_SR_EXIT` to `ST_SR_BURST_OUT`, or to `ST_IDLE` when the burst length is zero.
- Burst done: `ST_SR_BURST_OUT` to `ST_IDLE`.

Top module: `dram_rfsh_mgr`

## Requirements
- R1: After reset `ras_n` and `cas_n` are high and `ref_req`, `init_done` and `sleeping` are low. Neither strobe falls during the first PWRUP_CYC cycles.
- R2: After the pause, exactly INIT_CBRS CBR cycles run and then `init_done` rises. Once high, it stays high.
- R3: In every cycle of the strobes, `cas_n` falls while `ras_n` is high and `ras_n` falls one clock later while `cas_n` is low. In a refresh, `ras_n` stays low for exactly RAS_CYC clocks, and both strobes then rise on the same edge.
- R4: After each strobe cycle, both strobes stay high for at least PRE_CYC clocks before `cas_n` falls again.
- R5: One refresh falls due every INTERVAL_CYC clocks, counted from the end of priming or from a self-refresh exit. Each due refresh raises `ref_req` and is issued as one CBR cycle.
- R6: At most MAX_PEND refreshes are held pending. When the grant returns after a longer wait, exactly MAX_PEND CBR cycles run back to back, and then `ref_req` falls.
- R7: While `grant` is low no strobe cycle starts. Any refresh that falls due in that time is only counted.
- R8: `sleep_req` seen in idle causes BURST_ROWS CBR cycles and then one further CAS-first cycle that is held with both strobes low. `sleeping` is high exactly while that hold has `ras_n` low.
- R9: Self-refresh keeps `ras_n` low for at least SR_MIN_CYC clocks, even if `sleep_req` drops earlier. It ends within two clocks after that minimum once `sleep_req` is low.
- R10: On leaving self-refresh both strobes stay high for at least PRE_CYC+SR_REC_CYC clocks. Then BURST_ROWS CBR cycles run, and `ref_req` falls.
- R11: Refreshes that fell due during sleep are discarded on exit, and no extra CBR cycle follows the exit burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Host asks for self-refresh while high |
| grant | input | 1 | Access controller lets this block drive the strobes |
| ref_req | output | 1 | This block needs the strobes |
| init_done | output | 1 | Priming finished; normal accesses allowed |
| sleeping | output | 1 | DRAM is held in self-refresh |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |

## Verification
The bench builds the manager with a 50-clock pause, 8 priming cycles, a 200-clock interval, a pending ceiling of 3, RAS_CYC 4, PRE_CYC 3, a 40-clock self-refresh minimum, a 5-clock recovery and 4-cycle bursts. These values put every timer within a few hundred clocks. As a result, pending refreshes can reach the ceiling, a sleep can span several intervals so that the discard on exit can be seen, and both sleep bursts complete in one short run. A monitor on the strobes counts CAS-first falls and measures low and high widths, so every check is made on pin behaviour alone.

// File: rtl/dram_rfsh_pkg.sv
`timescale 1ns/1ps
package dram_rfsh_pkg;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_INIT_CBR,
        ST_IDLE,
        ST_REQ,
        ST_CBR,
        ST_SR_BURST_IN,
        ST_SELF,
        ST_SR_EXIT,
        ST_SR_BURST_OUT
    } mgr_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CAS,
        SQ_RAS,
        SQ_PRE
    } seq_state_e;

endpackage

// File: rtl/rfsh_interval.sv
`timescale 1ns/1ps
module rfsh_interval #(
    parameter int INTERVAL_CYC = 3200,
    parameter int MAX_PEND     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             pop,
    output logic                             due,
    output logic [$clog2(MAX_PEND+1)-1:0]    pend
);
    localparam int CW = $clog2(INTERVAL_CYC);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [CW-1:0] TICK_AT = CW'(INTERVAL_CYC - 1);
    localparam logic [PW-1:0] PEND_TOP = PW'(MAX_PEND);

    logic [CW-1:0] cnt_q;
    logic [PW-1:0] pend_q;
    logic          tick, inc, dec;

    assign tick = (cnt_q == TICK_AT);
    assign dec  = pop && (pend_q != '0);
    assign inc  = tick && ((pend_q != PEND_TOP) || dec);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
            pend_q <= '0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
            if (inc && !dec)
                pend_q <= pend_q + 1'b1;
            else if (dec && !inc)
                pend_q <= pend_q - 1'b1;
        end
    end

    assign due  = (pend_q != '0);
    assign pend = pend_q;

    // R6
    pend_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_TOP);

endmodule

// File: rtl/rfsh_cbr_seq.sv
`timescale 1ns/1ps
module rfsh_cbr_seq
    import dram_rfsh_pkg::*;
#(
    parameter int RAS_CYC = 14,
    parameter int PRE_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic done
);
    localparam int MAXC = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYC - 1);

    seq_state_e    st_q;
    logic [CW-1:0] cnt_q;
    logic          ras_q, cas_q, done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            cnt_q  <= '0;
            ras_q  <= 1'b1;
            cas_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                SQ_IDLE: begin
                    if (start) begin
                        st_q  <= SQ_CAS;
                        cas_q <= 1'b0;
                    end
                end
                SQ_CAS: begin
                    st_q  <= SQ_RAS;
                    ras_q <= 1'b0;
                    cnt_q <= '0;
                end
                SQ_RAS: begin
                    if (cnt_q == RAS_LAST) begin
                        if (!hold) begin
                            st_q  <= SQ_PRE;
                            ras_q <= 1'b1;
                            cas_q <= 1'b1;
                            cnt_q <= '0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_PRE: begin
                    if (cnt_q == PRE_LAST) begin
                        st_q   <= SQ_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign ras_n = ras_q;
    assign cas_n = cas_q;
    assign busy  = (st_q != SQ_IDLE);
    assign done  = done_q;

    // R3
    cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_q) |-> ras_q);
    // R3
    ras_under_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_q) |-> !cas_q);
    // R4
    precharge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_q) |=> (ras_q && cas_q));

endmodule

// File: rtl/dram_rfsh_mgr.sv
`timescale 1ns/1ps
module dram_rfsh_mgr
    import dram_rfsh_pkg::*;
#(
    parameter int PWRUP_CYC    = 40000,
    parameter int INIT_CBRS    = 8,
    parameter int INTERVAL_CYC = 3200,
    parameter int MAX_PEND     = 8,
    parameter int RAS_CYC      = 14,
    parameter int PRE_CYC      = 10,
    parameter int SR_MIN_CYC   = 20001,
    parameter int SR_REC_CYC   = 25,
    parameter int BURST_ROWS   = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic grant,
    output logic ref_req,
    output logic init_done,
    output logic sleeping,
    output logic ras_n,
    output logic cas_n
);
    localparam int WAIT_A   = (PWRUP_CYC > SR_MIN_CYC) ? PWRUP_CYC : SR_MIN_CYC;
    localparam int WAIT_MAX = (WAIT_A > SR_REC_CYC) ? WAIT_A : SR_REC_CYC;
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int OPS_MAX  = (INIT_CBRS > BURST_ROWS) ? INIT_CBRS : BURST_ROWS;
    localparam int OPS_W    = $clog2(OPS_MAX + 1);
    localparam int PEND_W   = $clog2(MAX_PEND + 1);
    localparam logic [WAIT_W-1:0] PWR_LAST = WAIT_W'(PWRUP_CYC - 1);
    localparam logic [WAIT_W-1:0] SR_MIN_W = WAIT_W'(SR_MIN_CYC);
    localparam logic [WAIT_W-1:0] REC_LAST = WAIT_W'(SR_REC_CYC - 1);

    mgr_state_e        state_q, state_d;
    mgr_state_e        sleep_in_st, sleep_out_st;
    logic [WAIT_W-1:0] wait_q;
    logic [OPS_W-1:0]  ops_q;
    logic              init_q;
    logic              seq_start, seq_hold, seq_busy, seq_done;
    logic              tmr_clr, tmr_pop, due;
    logic [PEND_W-1:0] pend;

    // Burst length of zero removes both burst states from the sleep path.
    generate
        if (BURST_ROWS > 0) begin : g_burst
            assign sleep_in_st  = ST_SR_BURST_IN;
            assign sleep_out_st = ST_SR_BURST_OUT;
        end else begin : g_no_burst
            assign sleep_in_st  = ST_SELF;
            assign sleep_out_st = ST_IDLE;
        end
    endgenerate

    rfsh_interval #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .MAX_PEND     (MAX_PEND)
    ) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .pop   (tmr_pop),
        .due   (due),
        .pend  (pend)
    );

    rfsh_cbr_seq #(
        .RAS_CYC (RAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .hold  (seq_hold),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .busy  (seq_busy),
        .done  (seq_done)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWR_WAIT:
                if (wait_q == PWR_LAST) state_d = ST_INIT_CBR;
            ST_INIT_CBR:
                if (ops_q == '0 && seq_done) state_d = ST_IDLE;
            ST_IDLE:
                if (sleep_req)  state_d = sleep_in_st;
                else if (due)   state_d = ST_REQ;
            ST_REQ:
                if (seq_start)  state_d = ST_CBR;
            ST_CBR:
                if (seq_done)
                    state_d = (pend > PEND_W'(1)) ? ST_REQ : ST_IDLE;
            ST_SR_BURST_IN:
                if (ops_q == '0 && seq_done) state_d = ST_SELF;
            ST_SELF:
                if (!sleep_req && wait_q == SR_MIN_W) state_d = ST_SR_EXIT;
            ST_SR_EXIT:
                if (!seq_busy && wait_q == REC_LAST) state_d = sleep_out_st;
            ST_SR_BURST_OUT:
                if (ops_q == '0 && seq_done) state_d = ST_IDLE;
            default: state_d = ST_PWR_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWR_WAIT;
        else        state_q <= state_d;
    end

    // Per-state counters and the sticky priming flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            ops_q  <= '0;
            init_q <= 1'b0;
        end else begin
            if (state_q == ST_INIT_CBR && state_d == ST_IDLE)
                init_q <= 1'b1;

            if (state_d != state_q) begin
                unique case (state_d)
                    ST_INIT_CBR:                     ops_q <= OPS_W'(INIT_CBRS);
                    ST_SR_BURST_IN, ST_SR_BURST_OUT: ops_q <= OPS_W'(BURST_ROWS);
                    default:                         ops_q <= '0;
                endcase
            end else if (seq_start && ops_q != '0) begin
                ops_q <= ops_q - 1'b1;
            end

            if (state_d != state_q) begin
                wait_q <= '0;
            end else begin
                unique case (state_q)
                    ST_PWR_WAIT: wait_q <= wait_q + 1'b1;
                    ST_SELF:
                        if (!ras_n && wait_q != SR_MIN_W) wait_q <= wait_q + 1'b1;
                    ST_SR_EXIT:
                        if (!seq_busy && wait_q != REC_LAST) wait_q <= wait_q + 1'b1;
                    default: wait_q <= wait_q;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        seq_start = 1'b0;
        seq_hold  = (state_q == ST_SELF);
        unique case (state_q)
            ST_INIT_CBR, ST_SR_BURST_IN, ST_SR_BURST_OUT:
                seq_start = (ops_q != '0) && grant && !seq_busy;
            ST_REQ, ST_SELF:
                seq_start = grant && !seq_busy;
            default: seq_start = 1'b0;
        endcase
        ref_req   = (state_q != ST_PWR_WAIT) && (state_q != ST_IDLE);
        sleeping  = (state_q == ST_SELF) && !ras_n;
        init_done = init_q;
        tmr_pop   = (state_q == ST_CBR) && seq_done;
        tmr_clr   = (state_q == ST_INIT_CBR && state_d == ST_IDLE) ||
                    (state_q == ST_SELF && state_d == ST_SR_EXIT);
    end

    // R1
    pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWR_WAIT) |-> (ras_n && cas_n));
    // R2
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    // R7
    grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(grant));
    // R8
    sleep_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping |-> !cas_n);

endmodule

// File: tb/dram_rfsh_mgr_tb.sv
`timescale 1ns/1ps
module dram_rfsh_mgr_tb;
    localparam int PWRUP = 50;
    localparam int NINIT = 8;
    localparam int INTV  = 200;
    localparam int MAXP  = 3;
    localparam int RASC  = 4;
    localparam int PREC  = 3;
    localparam int SRMIN = 40;
    localparam int RECC  = 5;
    localparam int BURST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic grant = 1'b1;
    logic ref_req, init_done, sleeping, ras_n, cas_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // strobe monitor state
    int  cbr_cnt = 0;
    int  order_err = 0;
    int  grant_err = 0;
    int  ras_run = 0;
    int  last_ras_low = 0;
    int  hi_run = 0;
    int  last_hi_run = 0;
    int  min_gap = 100000;
    logic prev_ras = 1'b1;
    logic prev_cas = 1'b1;

    always #2.5 clk = ~clk;

    dram_rfsh_mgr #(
        .PWRUP_CYC    (PWRUP),
        .INIT_CBRS    (NINIT),
        .INTERVAL_CYC (INTV),
        .MAX_PEND     (MAXP),
        .RAS_CYC      (RASC),
        .PRE_CYC      (PREC),
        .SR_MIN_CYC   (SRMIN),
        .SR_REC_CYC   (RECC),
        .BURST_ROWS   (BURST)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .grant     (grant),
        .ref_req   (ref_req),
        .init_done (init_done),
        .sleeping  (sleeping),
        .ras_n     (ras_n),
        .cas_n     (cas_n)
    );

    always @(negedge clk) begin
        cycles++;
        if (prev_cas && !cas_n && prev_ras && ras_n) begin
            cbr_cnt++;
            last_hi_run = hi_run;
            if (cbr_cnt > 1 && hi_run < min_gap) min_gap = hi_run;
            if (!grant) grant_err++;
        end
        if (prev_ras && !ras_n && cas_n) order_err++;
        if (!prev_ras && ras_n) last_ras_low = ras_run;
        ras_run = ras_n ? 0 : ras_run + 1;
        hi_run  = (ras_n && cas_n) ? hi_run + 1 : 0;
        prev_ras = ras_n;
        prev_cas = cas_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n == 1'b1, "R1 ras_n after reset", int'(ras_n), 1);
        chk(cas_n == 1'b1, "R1 cas_n after reset", int'(cas_n), 1);
        chk(ref_req == 1'b0, "R1 ref_req after reset", int'(ref_req), 0);
        chk(init_done == 1'b0, "R1 init_done after reset", int'(init_done), 0);
        chk(sleeping == 1'b0, "R1 sleeping after reset", int'(sleeping), 0);
        repeat (PWRUP - 4) @(negedge clk);
        chk(cbr_cnt == 0, "R1 no strobe during pause", cbr_cnt, 0);
    endtask

    task automatic t_init();
        for (int i = 0; i < 600 && !init_done; i++) @(negedge clk);
        chk(init_done == 1'b1, "R2 init_done rises", int'(init_done), 1);
        chk(cbr_cnt == NINIT, "R2 priming cycle count", cbr_cnt, NINIT);
        chk(last_ras_low == RASC, "R3 ras low width", last_ras_low, RASC);
        chk(order_err == 0, "R3 ras fell with cas high", order_err, 0);
        chk(min_gap >= PREC, "R4 precharge between cycles", min_gap, PREC);
        @(negedge clk);
        chk(ref_req == 1'b0, "R2 ref_req low after priming", int'(ref_req), 0);
    endtask

    task automatic t_interval();
        int base;
        base = cbr_cnt;
        repeat (2 * INTV + 20) @(negedge clk);
        chk(cbr_cnt - base == 2, "R5 refreshes in two intervals", cbr_cnt - base, 2);
        chk(init_done == 1'b1, "R2 init_done stays high", int'(init_done), 1);
    endtask

    task automatic t_postpone();
        int base;
        for (int i = 0; i < INTV + 10 && !ref_req; i++) @(negedge clk);
        chk(ref_req == 1'b1, "R5 ref_req on due refresh", int'(ref_req), 1);
        for (int i = 0; i < 50 && ref_req; i++) @(negedge clk);
        grant = 1'b0;
        base = cbr_cnt;
        repeat (5 * INTV) @(negedge clk);
        chk(cbr_cnt == base, "R7 no cycle without grant", cbr_cnt - base, 0);
        chk(ref_req == 1'b1, "R7 ref_req held without grant", int'(ref_req), 1);
        grant = 1'b1;
        repeat (60) @(negedge clk);
        chk(cbr_cnt - base == MAXP, "R6 pending ceiling issued", cbr_cnt - base, MAXP);
        chk(ref_req == 1'b0, "R6 ref_req falls after catch-up", int'(ref_req), 0);
        chk(grant_err == 0, "R7 cas fell while grant low", grant_err, 0);
    endtask

    task automatic t_long_sleep();
        int base;
        int hi_after;
        base = cbr_cnt;
        sleep_req = 1'b1;
        for (int i = 0; i < 300 && !sleeping; i++) @(negedge clk);
        chk(sleeping == 1'b1, "R8 sleeping rises", int'(sleeping), 1);
        chk(cbr_cnt - base == BURST + 1, "R8 entry burst plus hold", cbr_cnt - base, BURST + 1);
        chk(!ras_n && !cas_n, "R8 both strobes low in sleep", int'({ras_n, cas_n}), 0);
        repeat (3 * INTV) @(negedge clk);
        chk(sleeping == 1'b1, "R9 sleep held while requested", int'(sleeping), 1);
        sleep_req = 1'b0;
        for (int i = 0; i < 10 && sleeping; i++) @(negedge clk);
        chk(sleeping == 1'b0, "R9 sleep ends on release", int'(sleeping), 0);
        base = cbr_cnt;
        for (int i = 0; i < 100 && cbr_cnt == base; i++) @(negedge clk);
        hi_after = last_hi_run;
        chk(hi_after >= PREC + RECC, "R10 recovery high time", hi_after, PREC + RECC);
        for (int i = 0; i < 200 && ref_req; i++) @(negedge clk);
        chk(cbr_cnt - base == BURST, "R10 exit burst count", cbr_cnt - base, BURST);
        repeat (40) @(negedge clk);
        chk(cbr_cnt - base == BURST, "R11 no stale refresh after exit", cbr_cnt - base, BURST);
        chk(ref_req == 1'b0, "R11 ref_req low after exit", int'(ref_req), 0);
    endtask

    task automatic t_short_sleep();
        int n;
        sleep_req = 1'b1;
        for (int i = 0; i < 300 && !sleeping; i++) @(negedge clk);
        sleep_req = 1'b0;
        n = 1;
        for (int i = 0; i < 300 && sleeping; i++) begin
            @(negedge clk);
            if (sleeping) n++;
        end
        chk(n >= SRMIN, "R9 minimum self-refresh", n, SRMIN);
        chk(n <= SRMIN + 3, "R9 prompt exit after minimum", n, SRMIN + 1);
        repeat (3) @(negedge clk);
        chk(last_ras_low >= SRMIN, "R9 ras low in self-refresh", last_ras_low, SRMIN);
        for (int i = 0; i < 200 && ref_req; i++) @(negedge clk);
        chk(ref_req == 1'b0, "R10 back to idle", int'(ref_req), 0);
        chk(order_err == 0, "R3 strobe order overall", order_err, 0);
        chk(min_gap >= PREC, "R4 precharge overall", min_gap, PREC);
    endtask

    initial begin
        t_reset();
        t_init();
        t_interval();
        t_postpone();
        t_long_sleep();
        t_short_sleep();
        finish_run();
    end

endmodule